// File: doc/BRIEF.md
# Almost-Empty / Almost-Full Offset Loader

This block owns the two threshold registers that drive the almost-empty and almost-full flags of a 16K-word FIFO. X is the almost-empty offset and Y is the almost-full offset. The three select pins are sampled while the full reset is held. Their value at the last clock edge with reset low fixes the loading method until the next full reset. The select code either gives both registers one of five preset values, or asks for the values to be loaded. A load comes in bit by bit on a serial data/enable pin pair, or as the first two accepted words of the write stream.

The write side is a valid/ready stream. A word transfers on a rising clock edge where `wr_valid` and `wr_ready` are both high. The source must hold `wr_valid` and `wr_data` until that edge. The block drops `wr_ready` for as long as a serial load is in progress and for as long as the FIFO reports full. During a parallel load it keeps `wr_ready` high, because the offset words never reach the FIFO. `store_en` tells the FIFO write path that the transfer in the current cycle is a data word to be stored.

The flags are combinational comparisons of a supplied word count against X and of the remaining free space against Y. The RAM, the pointers and the read side sit outside this block.

Top module: `fifo_offset_cfg`

## Requirements
- R1: The select code `sel_fs` = {s2,s1,s0} is sampled at the last clock edge with `rst_n` low. The codes 111, 110, 101, 011 and 001 load both X and Y with 64, 16, 8, 256 and 1024 respectively. After reset release, `wr_ready` follows `!fifo_full`.
- R2: Code 010 selects serial loading. The first 14 bits go into Y and the next 14 bits go into X, each register most significant bit first.
- R3: In serial mode `wr_ready` stays low until all 28 bits are in. It rises at the clock edge after the edge that takes the 28th bit.
- R4: A serial bit is taken only on an edge where `ser_en_n` is low. An edge with `ser_en_n` high takes no bit and changes neither offset.
- R5: Codes 100 and 000 select parallel loading. The first accepted transfer after reset loads Y and the second loads X. Neither one raises `store_en`. The third accepted transfer raises `store_en`.
- R6: With code 100, the offset field is `wr_data[13:0]`.
- R7: With code 000, `wr_data[8]` is ignored. The offset is {`wr_data[14:9]`, `wr_data[7:0]`}, with bit 14 as the most significant bit.
- R8: During a parallel load `wr_ready` is high even when `fifo_full` is high. Once loading is complete, `wr_ready` equals `!fifo_full`, and `store_en` equals `wr_valid && wr_ready`.
- R9: `almost_empty` is high exactly when `used_cnt` <= X.
- R10: `almost_full` is high exactly when 16384 - `used_cnt` <= Y.
- R11: Once loading is complete, X, Y and the mode do not change until the next full reset, whatever `sel_fs`, `ser_en_n`, `ser_din` or the write stream do.
- R12: Offset values from 1 to 16380 are loaded and reported on `off_x`/`off_y` exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write-side clock |
| rst_n | input | 1 | Full reset, active low, synchronous; the select code is sampled while it is low |
| sel_fs | input | 3 | Loading method / preset select |
| ser_en_n | input | 1 | Serial load enable, active low |
| ser_din | input | 1 | Serial offset data |
| fifo_full | input | 1 | FIFO has no free word |
| used_cnt | input | 15 | Number of words stored in the FIFO (0..16384) |
| wr_valid | input | 1 | Write stream valid |
| wr_data | input | 36 | Write stream data |
| wr_ready | output | 1 | Write stream ready |
| store_en | output | 1 | Current transfer is a data word to be stored |
| off_x | output | 14 | Almost-empty offset |
| off_y | output | 14 | Almost-full offset |
| almost_empty | output | 1 | Stored count at or below X |
| almost_full | output | 1 | Free space at or below Y |

## Verification
The assertions check on every cycle that the serial bit counter never goes past 28 and advances only on enabled edges. They also check that the parallel word counter stops at two, that `wr_ready` stays low during an unfinished serial load, and that the offsets hold once loading is complete. Some behaviours only the bench scenarios can show: the value each select code produces, the Y-then-X order and MSB-first assembly, the dropped bit 8 in the parity layout, the exact edge where `wr_ready` rises, and the flag thresholds at X, X+1, 16384-Y and 16384-Y-1.

// File: rtl/fcl_pkg.sv
package fcl_pkg;

  typedef enum logic [1:0] {
    LM_PRESET     = 2'd0,
    LM_SERIAL     = 2'd1,
    LM_PAR_FLAT   = 2'd2,
    LM_PAR_PARITY = 2'd3
  } load_mode_e;

  function automatic load_mode_e mode_of(input logic [2:0] code);
    case (code)
      3'b010:  mode_of = LM_SERIAL;
      3'b100:  mode_of = LM_PAR_FLAT;
      3'b000:  mode_of = LM_PAR_PARITY;
      default: mode_of = LM_PRESET;
    endcase
  endfunction

  function automatic logic [15:0] preset_of(input logic [2:0] code);
    case (code)
      3'b111:  preset_of = 16'd64;
      3'b110:  preset_of = 16'd16;
      3'b101:  preset_of = 16'd8;
      3'b011:  preset_of = 16'd256;
      3'b001:  preset_of = 16'd1024;
      default: preset_of = 16'd0;
    endcase
  endfunction

endpackage

// File: rtl/fcl_mode_capture.sv
module fcl_mode_capture
  import fcl_pkg::*;
#(
  parameter int OFW = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        sel_fs,
  output load_mode_e        mode,
  output logic [OFW-1:0]    preset_val
);

  logic [15:0] raw_preset;
  assign raw_preset = preset_of(sel_fs);

  // The select code is captured on every edge that sees reset low;
  // the last such edge decides the mode.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode       <= mode_of(sel_fs);
      preset_val <= raw_preset[OFW-1:0];
    end
  end

  logic unused_preset_hi;
  assign unused_preset_hi = ^raw_preset[15:OFW];

  // R11: the mode is frozen outside reset
  assert_mode_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(mode));

endmodule

// File: rtl/fcl_serial_loader.sv
module fcl_serial_loader #(
  parameter int OFW = 14
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           active,
  input  logic           ser_en_n,
  input  logic           ser_din,
  output logic [OFW-1:0] y_val,
  output logic [OFW-1:0] x_val,
  output logic           done
);

  localparam int TOTAL = 2 * OFW;
  localparam int CW    = $clog2(TOTAL + 1);

  logic [CW-1:0] bit_cnt;
  logic          take;

  assign take = active && !ser_en_n && (bit_cnt < CW'(TOTAL));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      y_val   <= '0;
      x_val   <= '0;
      done    <= 1'b0;
    end else begin
      if (take) begin
        bit_cnt <= bit_cnt + 1'b1;
        if (bit_cnt < CW'(OFW)) y_val <= {y_val[OFW-2:0], ser_din};
        else                    x_val <= {x_val[OFW-2:0], ser_din};
      end
      // ready follows one edge after the final bit
      done <= active && (bit_cnt == CW'(TOTAL));
    end
  end

  // R2: never more than 2*OFW bits accepted
  assert_bit_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= CW'(TOTAL));

  // R4: the count moves only after an enabled edge
  assert_enable_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && bit_cnt != $past(bit_cnt)) |-> !$past(ser_en_n));

endmodule

// File: rtl/fcl_parallel_loader.sv
module fcl_parallel_loader #(
  parameter int DW  = 36,
  parameter int OFW = 14
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           active,
  input  logic           parity_layout,
  input  logic           accept,
  input  logic [DW-1:0]  data,
  output logic [OFW-1:0] y_val,
  output logic [OFW-1:0] x_val,
  output logic           done
);

  logic [1:0]     word_cnt;
  logic [OFW-1:0] flat_field;
  logic [OFW-1:0] parity_field;
  logic [OFW-1:0] field;

  generate
    if (OFW > 9) begin : g_wide
      assign parity_field = {data[OFW:9], data[7:0]};
    end else begin : g_narrow
      assign parity_field = data[OFW-1:0];
    end
  endgenerate

  assign flat_field = data[OFW-1:0];
  assign field      = parity_layout ? parity_field : flat_field;
  assign done       = (word_cnt == 2'd2);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_cnt <= '0;
      y_val    <= '0;
      x_val    <= '0;
    end else if (active && accept && !done) begin
      word_cnt <= word_cnt + 1'b1;
      if (word_cnt == 2'd0) y_val <= field;
      else                  x_val <= field;
    end
  end

  logic unused_hi_bits;
  assign unused_hi_bits = ^data[DW-1:OFW+1];

  // R5: exactly two offset words are consumed
  assert_word_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    word_cnt <= 2'd2);

endmodule

// File: rtl/fcl_flag_cmp.sv
module fcl_flag_cmp #(
  parameter int DEPTH = 16384,
  parameter int OFW   = 14,
  parameter int UW    = 15
) (
  input  logic [UW-1:0]  used_cnt,
  input  logic [OFW-1:0] x_val,
  input  logic [OFW-1:0] y_val,
  output logic           almost_empty,
  output logic           almost_full
);

  logic [UW-1:0] free_cnt;

  assign free_cnt     = UW'(DEPTH) - used_cnt;
  assign almost_empty = (used_cnt <= UW'(x_val));
  assign almost_full  = (free_cnt <= UW'(y_val));

endmodule

// File: rtl/fifo_offset_cfg.sv
module fifo_offset_cfg
  import fcl_pkg::*;
#(
  parameter int DEPTH = 16384,
  parameter int DW    = 36,
  parameter int OFW   = $clog2(DEPTH),
  parameter int UW    = $clog2(DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [2:0]     sel_fs,
  input  logic           ser_en_n,
  input  logic           ser_din,
  input  logic           fifo_full,
  input  logic [UW-1:0]  used_cnt,
  input  logic           wr_valid,
  input  logic [DW-1:0]  wr_data,
  output logic           wr_ready,
  output logic           store_en,
  output logic [OFW-1:0] off_x,
  output logic [OFW-1:0] off_y,
  output logic           almost_empty,
  output logic           almost_full
);

  load_mode_e     mode;
  logic [OFW-1:0] preset_val;
  logic [OFW-1:0] ser_y, ser_x, par_y, par_x;
  logic           ser_done, par_done, cfg_done;
  logic           is_serial, is_par, accept;

  fcl_mode_capture #(.OFW(OFW)) u_mode (
    .clk(clk), .rst_n(rst_n), .sel_fs(sel_fs),
    .mode(mode), .preset_val(preset_val)
  );

  assign is_serial = (mode == LM_SERIAL);
  assign is_par    = (mode == LM_PAR_FLAT) || (mode == LM_PAR_PARITY);

  fcl_serial_loader #(.OFW(OFW)) u_ser (
    .clk(clk), .rst_n(rst_n), .active(is_serial),
    .ser_en_n(ser_en_n), .ser_din(ser_din),
    .y_val(ser_y), .x_val(ser_x), .done(ser_done)
  );

  assign accept = wr_valid && wr_ready;

  fcl_parallel_loader #(.DW(DW), .OFW(OFW)) u_par (
    .clk(clk), .rst_n(rst_n), .active(is_par),
    .parity_layout(mode == LM_PAR_PARITY),
    .accept(accept), .data(wr_data),
    .y_val(par_y), .x_val(par_x), .done(par_done)
  );

  always_comb begin
    case (mode)
      LM_SERIAL: begin
        off_x = ser_x; off_y = ser_y; cfg_done = ser_done;
      end
      LM_PAR_FLAT, LM_PAR_PARITY: begin
        off_x = par_x; off_y = par_y; cfg_done = par_done;
      end
      default: begin
        off_x = preset_val; off_y = preset_val; cfg_done = 1'b1;
      end
    endcase
  end

  always_comb begin
    if (!rst_n)                   wr_ready = 1'b0;
    else if (is_par && !par_done) wr_ready = 1'b1;
    else if (!cfg_done)           wr_ready = 1'b0;
    else                          wr_ready = !fifo_full;
  end

  assign store_en = accept && cfg_done;

  fcl_flag_cmp #(.DEPTH(DEPTH), .OFW(OFW), .UW(UW)) u_flags (
    .used_cnt(used_cnt), .x_val(off_x), .y_val(off_y),
    .almost_empty(almost_empty), .almost_full(almost_full)
  );

  // R3: no transfers while a serial load is unfinished
  assert_serial_block_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (is_serial && !ser_done) |-> !wr_ready);

  // R11: offsets frozen once loading has finished
  assert_offset_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(cfg_done) && cfg_done) |-> ($stable(off_x) && $stable(off_y)));

  // R5: an offset word is never also stored
  assert_no_store_in_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (is_par && !par_done) |-> !store_en);

endmodule

// File: tb/sim_fifo_offset_cfg.sv
module sim_fifo_offset_cfg;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16384;
  localparam int OFW = 14;
  localparam int UW = 15;
  localparam int DW = 36;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [2:0]     sel_fs = 3'b111;
  logic           ser_en_n = 1'b1;
  logic           ser_din = 1'b0;
  logic           fifo_full = 1'b0;
  logic [UW-1:0]  used_cnt = '0;
  logic           wr_valid = 1'b0;
  logic [DW-1:0]  wr_data = '0;
  logic           wr_ready, store_en, almost_empty, almost_full;
  logic [OFW-1:0] off_x, off_y;

  int n_checks = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fifo_offset_cfg u0 (
    .clk(clk), .rst_n(rst_n), .sel_fs(sel_fs), .ser_en_n(ser_en_n),
    .ser_din(ser_din), .fifo_full(fifo_full), .used_cnt(used_cnt),
    .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready),
    .store_en(store_en), .off_x(off_x), .off_y(off_y),
    .almost_empty(almost_empty), .almost_full(almost_full)
  );

  function automatic int exp_preset(input logic [2:0] c);
    case (c)
      3'b111: return 64;
      3'b110: return 16;
      3'b101: return 8;
      3'b011: return 256;
      3'b001: return 1024;
      default: return 0;
    endcase
  endfunction

  function automatic logic [OFW-1:0] exp_field(input logic [DW-1:0] d, input bit parity);
    if (parity) return {d[14:9], d[7:0]};
    return d[13:0];
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic do_reset(input logic [2:0] code);
    tick();
    rst_n = 1'b0; sel_fs = code; wr_valid = 1'b0; ser_en_n = 1'b1; fifo_full = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
    sel_fs = 3'($urandom);
    #1;
  endtask

  task automatic check_flags(input int x, input int y, input int used, input string tag);
    used_cnt = UW'(used);
    #1;
    check({tag, " R9 almost_empty"}, int'(almost_empty), (used <= x) ? 1 : 0);
    check({tag, " R10 almost_full"}, int'(almost_full), ((DEPTH - used) <= y) ? 1 : 0);
  endtask

  task automatic flag_sweep(input int x, input int y);
    check_flags(x, y, x, "edge");
    check_flags(x, y, x + 1, "edge");
    check_flags(x, y, DEPTH - y, "edge");
    check_flags(x, y, DEPTH - y - 1, "edge");
    check_flags(x, y, 0, "edge");
    check_flags(x, y, DEPTH, "edge");
    for (int k = 0; k < 6; k++) check_flags(x, y, int'($urandom_range(DEPTH, 0)), "rand");
  endtask

  task automatic serial_load(input int y, input int x);
    logic [27:0] bits;
    bits = {y[13:0], x[13:0]};
    for (int i = 27; i >= 0; i--) begin
      if ($urandom_range(3, 0) == 0) begin
        ser_en_n = 1'b1; ser_din = ~bits[i];
        tick(); #1;
        check("R4 paused ready", int'(wr_ready), 0);
      end
      ser_en_n = 1'b0; ser_din = bits[i];
      tick();
    end
    ser_en_n = 1'b1; ser_din = 1'b0;
    #1;
    check("R3 ready low right after last bit", int'(wr_ready), 0);
    tick(); #1;
    check("R3 ready high one edge later", int'(wr_ready), 1);
    check("R2 serial Y", int'(off_y), y);
    check("R2 serial X", int'(off_x), x);
  endtask

  task automatic parallel_case(input logic [2:0] code, input bit parity);
    logic [DW-1:0] d0, d1, d2;
    int y, x;
    do_reset(code);
    d0 = {$urandom, $urandom}; d1 = {$urandom, $urandom}; d2 = {$urandom, $urandom};
    y = int'(exp_field(d0, parity)); x = int'(exp_field(d1, parity));
    if (y == 0 || y > 16380) begin d0[3:0] = 4'd5; d0[14:9] = 6'd1; d0[13] = 1'b0; end
    if (x == 0 || x > 16380) begin d1[3:0] = 4'd9; d1[14:9] = 6'd2; d1[13] = 1'b0; end
    y = int'(exp_field(d0, parity)); x = int'(exp_field(d1, parity));
    fifo_full = 1'b1;
    wr_valid = 1'b1; wr_data = d0; #1;
    check("R8 ready during load despite full", int'(wr_ready), 1);
    check("R5 first word not stored", int'(store_en), 0);
    tick();
    wr_data = d1; #1;
    check("R5 second word not stored", int'(store_en), 0);
    tick();
    fifo_full = 1'b0; wr_data = d2; #1;
    check(parity ? "R7 parity-layout Y" : "R6 flat Y", int'(off_y), y);
    check(parity ? "R7 parity-layout X" : "R6 flat X", int'(off_x), x);
    check("R5 third word stored", int'(store_en), 1);
    tick();
    wr_valid = 1'b1; wr_data = {$urandom, $urandom}; #1;
    check("R11 X unchanged by later writes", int'(off_x), x);
    check("R11 Y unchanged by later writes", int'(off_y), y);
    fifo_full = 1'b1; #1;
    check("R8 ready drops when full", int'(wr_ready), 0);
    check("R8 no store when full", int'(store_en), 0);
    tick();
    wr_valid = 1'b0; fifo_full = 1'b0;
    flag_sweep(x, y);
  endtask

  initial begin
    logic [2:0] codes [5];
    void'($urandom(32'h5eed));
    codes[0] = 3'b111; codes[1] = 3'b110; codes[2] = 3'b101;
    codes[3] = 3'b011; codes[4] = 3'b001;

    // R1: reset state and every preset
    foreach (codes[i]) begin
      do_reset(codes[i]);
      check("R1 preset X", int'(off_x), exp_preset(codes[i]));
      check("R1 preset Y", int'(off_y), exp_preset(codes[i]));
      check("R1 ready after preset", int'(wr_ready), 1);
      wr_valid = 1'b1; #1;
      check("R8 store after preset", int'(store_en), 1);
      wr_valid = 1'b0;
      flag_sweep(exp_preset(codes[i]), exp_preset(codes[i]));
    end

    // R2/R3/R4/R12: serial loads including range limits
    for (int t = 0; t < 5; t++) begin
      int y, x;
      y = (t == 0) ? 1 : (t == 1) ? 16380 : int'($urandom_range(16380, 1));
      x = (t == 0) ? 16380 : (t == 1) ? 1 : int'($urandom_range(16380, 1));
      do_reset(3'b010);
      check("R3 ready low at serial start", int'(wr_ready), 0);
      serial_load(y, x);
      check("R12 legal range Y", int'(off_y), y);
      ser_en_n = 1'b0; ser_din = 1'b1; sel_fs = 3'($urandom);
      repeat (4) tick();
      ser_en_n = 1'b1; #1;
      check("R11 serial X held", int'(off_x), x);
      check("R11 serial Y held", int'(off_y), y);
      flag_sweep(x, y);
    end

    // R5/R6/R7/R8: parallel loads, both layouts
    for (int t = 0; t < 4; t++) begin
      parallel_case(3'b100, 1'b0);
      parallel_case(3'b000, 1'b1);
    end

    // R7: bit 8 has no effect in parity layout (directed)
    do_reset(3'b000);
    wr_valid = 1'b1; wr_data = 36'h0_0000_7F1F; tick();
    wr_data = 36'h0_0000_0E23; tick();
    wr_valid = 1'b0; #1;
    check("R7 bit8 ignored Y", int'(off_y), int'({6'h3F, 8'h1F}));
    check("R7 bit8 ignored X", int'(off_x), int'({6'h07, 8'h23}));

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule